// File: doc/BRIEF.md
# Writeback Slot Reservation Shift Register

This block sits at the issue stage of a pipeline with a single register-file write port. Every fixed-latency instruction books, at the moment it issues, the write cycle that lies exactly its unit's latency ahead. The bookings are held in a line of slot entries, each with a valid bit and a destination tag, and the line moves one place toward the head on every clock. The head entry drives the write enable and tag for the current cycle. Because each conflict is settled before issue, no result ever waits at a unit output.

An issue that targets a slot already booked is stalled and retried by the issuer in a later cycle with the same latency. A latency of zero, or a latency beyond the depth of the line, is rejected with an error flag. Variable-latency work, such as divide, cannot be booked. It is issued as a serialized operation. The block accepts it only when no fixed booking is outstanding, and it then blocks all issue until the unit reports done. The serialized result uses the write port in the done cycle.

Top module: `wb_slot_rsv`

## Requirements
- R1: After reset, every slot is empty: wb_en_o is 0, ser_busy_o is 0, and no request is outstanding.
- R2: A fixed issue with latency L (1..MAX_LAT) accepted in cycle t gives wb_en_o=1 with wb_tag_o equal to its tag in cycle t+L, and no write in cycles t+1..t+L-1 unless those cycles were booked by others.
- R3: A fixed issue whose target cycle is already booked gives iss_stall_o=1 and iss_accept_o=0. It books nothing. A retry in a later cycle whose target is free is accepted.
- R4: A fixed issue with latency 0 or above MAX_LAT gives iss_err_o=1 and iss_accept_o=0. It books nothing, and no write follows from it.
- R5: Fixed issues of equal latency accepted in consecutive cycles write back in issue order, one per cycle.
- R6: A serialized issue (iss_serial_i=1, latency ignored) is stalled while any fixed booking is outstanding. It is accepted in the first cycle in which the line is empty.
- R7: While a serialized operation is outstanding (ser_busy_o=1), every issue is stalled. ser_done_i then gives wb_en_o=1 with the serialized tag in that same cycle. Issue is accepted again from the next cycle.
- R8: iss_accept_o is never high together with iss_stall_o or iss_err_o, and at most one result writes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_req_i | input | 1 | Issue request this cycle |
| iss_serial_i | input | 1 | Request is a variable-latency (serialized) operation |
| iss_lat_i | input | LAT_W | Fixed latency in cycles |
| iss_tag_i | input | TAG_W | Destination tag |
| ser_done_i | input | 1 | Serialized unit finished; its result writes this cycle |
| iss_accept_o | output | 1 | Request accepted |
| iss_stall_o | output | 1 | Request must retry |
| iss_err_o | output | 1 | Fixed latency out of range |
| ser_busy_o | output | 1 | Serialized operation outstanding |
| wb_en_o | output | 1 | Register-file write enable this cycle |
| wb_tag_o | output | TAG_W | Register-file write tag this cycle |

## Verification
The hardest state to reach is a serialized request that arrives while fixed bookings are still in flight. That request must be held exactly until the last booking leaves the head, and it must then lock out a fixed issue. The bench books a latency-4 write, then retries a serialized request on every cycle. It counts the stalls before acceptance, probes a fixed issue during the busy period, and checks that the done cycle carries the serialized tag. A booking conflict is produced by following a latency-3 issue with a latency-2 issue one cycle later, since both target the same future cycle.

// File: rtl/wb_slot_pkg.sv
package wb_slot_pkg;
  localparam int unsigned MAX_LAT_DEF = 8;
  localparam int unsigned TAG_W_DEF   = 5;

  typedef enum logic [1:0] {
    ISS_NONE,
    ISS_FIXED,
    ISS_SERIAL
  } iss_kind_e;
endpackage

// File: rtl/wb_slot_line.sv
module wb_slot_line #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 5,
  parameter int unsigned LAT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             book_i,
  input  logic [LAT_W-1:0] book_lat_i,
  input  logic [TAG_W-1:0] book_tag_i,
  output logic             occ_o,
  output logic             head_vld_o,
  output logic [TAG_W-1:0] head_tag_o,
  output logic             empty_o
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];

  // Index L is the slot that reaches the head L cycles from now.
  always_comb begin
    occ_o = 1'b0;
    for (int i = 1; i < int'(DEPTH); i++)
      if (book_lat_i == LAT_W'(i)) occ_o = vld_q[i];
  end

  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_slot
    logic hit;
    assign hit = book_i && (book_lat_i == LAT_W'(i + 1));
    if (i == int'(DEPTH) - 1) begin : g_tail
      assign vld_d[i] = hit;
      assign tag_d[i] = hit ? book_tag_i : '0;
    end else begin : g_mid
      assign vld_d[i] = vld_q[i+1] | hit;
      assign tag_d[i] = hit ? book_tag_i : tag_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
      end else begin
        vld_q[i] <= vld_d[i];
        tag_q[i] <= tag_d[i];
      end
    end
  end

  assign head_vld_o = vld_q[0];
  assign head_tag_o = tag_q[0];
  assign empty_o    = ~|vld_q;

  p_book_lat1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (book_i && book_lat_i == LAT_W'(1)) |=> (head_vld_o && head_tag_o == $past(book_tag_i)));

  p_book_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    book_i |-> !occ_o);
endmodule

// File: rtl/wb_slot_ser.sv
module wb_slot_ser #(
  parameter int unsigned TAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAG_W-1:0] start_tag_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             wb_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             busy_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tag_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tag_q  <= start_tag_i;
    end else if (done_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign wb_o   = busy_q & done_i;
  assign tag_o  = tag_q;

  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);

  p_done_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |=> !busy_o);
endmodule

// File: rtl/wb_slot_rsv.sv
module wb_slot_rsv
  import wb_slot_pkg::*;
#(
  parameter int unsigned MAX_LAT = MAX_LAT_DEF,
  parameter int unsigned TAG_W   = TAG_W_DEF,
  localparam int unsigned LAT_W  = $clog2(MAX_LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iss_req_i,
  input  logic             iss_serial_i,
  input  logic [LAT_W-1:0] iss_lat_i,
  input  logic [TAG_W-1:0] iss_tag_i,
  input  logic             ser_done_i,
  output logic             iss_accept_o,
  output logic             iss_stall_o,
  output logic             iss_err_o,
  output logic             ser_busy_o,
  output logic             wb_en_o,
  output logic [TAG_W-1:0] wb_tag_o
);
  iss_kind_e        kind;
  logic             occ, head_vld, empty, ser_wb, book, ser_start;
  logic [TAG_W-1:0] head_tag, ser_tag;

  always_comb begin
    kind = ISS_NONE;
    if (iss_req_i) kind = iss_serial_i ? ISS_SERIAL : ISS_FIXED;
  end

  assign iss_err_o = (kind == ISS_FIXED) &&
                     (iss_lat_i == '0 || iss_lat_i > LAT_W'(MAX_LAT));

  always_comb begin
    iss_stall_o = 1'b0;
    unique case (kind)
      ISS_FIXED:  iss_stall_o = !iss_err_o && (occ || ser_busy_o);
      ISS_SERIAL: iss_stall_o = !empty || ser_busy_o;
      default:    iss_stall_o = 1'b0;
    endcase
  end

  assign iss_accept_o = iss_req_i && !iss_err_o && !iss_stall_o;
  assign book         = iss_accept_o && (kind == ISS_FIXED);
  assign ser_start    = iss_accept_o && (kind == ISS_SERIAL);

  wb_slot_line #(.DEPTH(MAX_LAT), .TAG_W(TAG_W), .LAT_W(LAT_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .book_i     (book),
    .book_lat_i (iss_lat_i),
    .book_tag_i (iss_tag_i),
    .occ_o      (occ),
    .head_vld_o (head_vld),
    .head_tag_o (head_tag),
    .empty_o    (empty)
  );

  wb_slot_ser #(.TAG_W(TAG_W)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (ser_start),
    .start_tag_i (iss_tag_i),
    .done_i      (ser_done_i),
    .busy_o      (ser_busy_o),
    .wb_o        (ser_wb),
    .tag_o       (ser_tag)
  );

  assign wb_en_o  = head_vld | ser_wb;
  assign wb_tag_o = head_vld ? head_tag : ser_tag;

  p_accept_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_accept_o |-> !(iss_stall_o || iss_err_o));

  p_one_writer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(head_vld && ser_wb));

  p_busy_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_busy_o |-> !iss_accept_o);

  p_serial_on_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_start |=> !head_vld);

  p_err_no_book_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_err_o |-> !iss_accept_o);
endmodule

// File: tb/sim_wb_slot_rsv.sv
module sim_wb_slot_rsv;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LAT = 8;
  localparam int TAG_W = 5;
  localparam int LAT_W = $clog2(MAX_LAT + 1);

  logic clk = 0, rst_ni = 0;
  logic iss_req = 0, iss_serial = 0, ser_done = 0;
  logic [LAT_W-1:0] iss_lat = '0;
  logic [TAG_W-1:0] iss_tag = '0;
  logic acc, stall, err, busy, wb_en;
  logic [TAG_W-1:0] wb_tag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic l_acc, l_stall, l_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_slot_rsv #(.MAX_LAT(MAX_LAT), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .iss_req_i(iss_req), .iss_serial_i(iss_serial),
    .iss_lat_i(iss_lat), .iss_tag_i(iss_tag), .ser_done_i(ser_done),
    .iss_accept_o(acc), .iss_stall_o(stall), .iss_err_o(err), .ser_busy_o(busy),
    .wb_en_o(wb_en), .wb_tag_o(wb_tag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_wb(input string req, input bit en, input int tag);
    #1;
    chk({req, " wb_en"}, int'(wb_en), int'(en));
    if (en) chk({req, " wb_tag"}, int'(wb_tag), tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one request for one cycle; returns at the next negedge.
  task automatic issue(input int lat, input int tag, input bit ser);
    iss_req = 1; iss_serial = ser; iss_lat = LAT_W'(lat); iss_tag = TAG_W'(tag);
    #1;
    l_acc = acc; l_stall = stall; l_err = err;
    @(negedge clk);
    iss_req = 0; iss_serial = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 wb_en", int'(wb_en), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 accept", int'(acc), 0);
  endtask

  task automatic t_basic;
    issue(3, 5, 0);
    chk("R2 accept", int'(l_acc), 1);
    chk_wb("R2 t+1", 0, 0);
    tick(1); chk_wb("R2 t+2", 0, 0);
    tick(1); chk_wb("R2 t+3", 1, 5);
    tick(1); chk_wb("R2 t+4", 0, 0);
  endtask

  task automatic t_conflict;
    issue(3, 1, 0);
    chk("R3 first accept", int'(l_acc), 1);
    issue(2, 2, 0);
    chk("R3 stall", int'(l_stall), 1);
    chk("R3 no accept", int'(l_acc), 0);
    issue(2, 2, 0);
    chk("R3 retry accept", int'(l_acc), 1);
    chk_wb("R3 first wb", 1, 1);
    tick(1); chk_wb("R3 retry wb", 1, 2);
    tick(1); chk_wb("R3 after", 0, 0);
  endtask

  task automatic t_range;
    issue(0, 6, 0);
    chk("R4 err lat0", int'(l_err), 1);
    chk("R4 no accept lat0", int'(l_acc), 0);
    issue(MAX_LAT + 1, 6, 0);
    chk("R4 err over", int'(l_err), 1);
    chk("R4 no accept over", int'(l_acc), 0);
    for (int i = 0; i < MAX_LAT + 1; i++) begin
      chk_wb("R4 no write", 0, 0);
      tick(1);
    end
    issue(MAX_LAT, 11, 0);
    chk("R4 max lat accept", int'(l_acc), 1);
    chk("R4 max lat no err", int'(l_err), 0);
    tick(MAX_LAT - 1);
    chk_wb("R2 max lat wb", 1, 11);
    tick(1);
  endtask

  task automatic t_order;
    issue(2, 7, 0); chk("R5 acc a", int'(l_acc), 1);
    issue(2, 8, 0); chk("R5 acc b", int'(l_acc), 1);
    chk_wb("R5 wb a", 1, 7);
    issue(2, 9, 0); chk("R5 acc c", int'(l_acc), 1);
    chk_wb("R5 wb b", 1, 8);
    tick(1); chk_wb("R5 wb c", 1, 9);
    tick(1); chk_wb("R5 idle", 0, 0);
  endtask

  task automatic t_serial;
    int stalls;
    stalls = 0;
    issue(4, 3, 0);
    chk("R6 fixed accept", int'(l_acc), 1);
    for (int i = 0; i < 10; i++) begin
      issue(0, 10, 1);
      if (l_acc) break;
      stalls++;
    end
    chk("R6 serial accepted", int'(l_acc), 1);
    chk("R6 stalls before empty", stalls, 4);
    #1;
    chk("R7 busy", int'(busy), 1);
    issue(1, 4, 0);
    chk("R7 fixed stalled", int'(l_stall), 1);
    chk("R7 fixed not accepted", int'(l_acc), 0);
    chk_wb("R7 no write while busy", 0, 0);
    ser_done = 1;
    chk_wb("R7 done write", 1, 10);
    @(negedge clk);
    ser_done = 0;
    #1;
    chk("R7 busy clear", int'(busy), 0);
    issue(1, 4, 0);
    chk("R7 issue after done", int'(l_acc), 1);
    chk_wb("R7 post wb", 1, 4);
    tick(1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_basic();
    t_conflict();
    t_range();
    t_order();
    t_serial();
    finish_run();
  end
endmodule